// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine with Sticky Error Flags

This block is the bit-level core of an asynchronous serial port. A transmit half takes one byte at a time through a single-entry holding buffer, wraps it in a start bit, an optional parity bit and one or two stop bits, and shifts it out on a line that idles high. A receive half watches the incoming line with a 16x oversampling tick. It qualifies start bits at their mid-point, samples every later bit at its centre, and hands each completed character to a one-entry read port with a valid flag.

Three error conditions are kept in sticky flags: a low stop bit, a parity mismatch, and a character that arrives while the previous one is still unread. Software never rewrites these flags directly. A single write-only command word carries one clear bit and one set bit per flag, plus a set and a clear bit for the receiver enable, so no read-modify-write is needed. The character format comes from a two-bit format code that selects data width and parity presence together, together with separate stop-count, parity-sense, parity-check and error-recording enables. These inputs are expected to stay stable while a character is in flight.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, `rx_valid` is 0, all three error flags are 0 and `rx_en` is 0.
- R2: A transmitted character is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits (high). Every bit lasts 16 `tick16` pulses. Format codes: `fmt`=00 gives 8 data bits with no parity, 01 gives 7 data bits plus parity, 10 gives 8 data bits plus parity, and 11 behaves as 00.
- R3: `two_stop`=1 sends two stop bits and makes the receiver check two stop bits. `two_stop`=0 uses one.
- R4: The parity bit is the XOR of the data bits when `par_odd`=0 (even parity) and its inverse when `par_odd`=1 (odd parity).
- R5: A `tx_we` pulse while `tx_empty`=1 loads `tx_data` into the holding buffer, and `tx_empty` is 0 in the next cycle. `tx_empty` returns to 1 in the cycle the byte moves into the shift register. A `tx_we` while `tx_empty`=0 is ignored.
- R6: The receiver samples each bit at oversampling count 8. A falling edge whose line is high again at that mid-point is discarded as noise and produces no character.
- R7: A completed character sets `rx_valid` and presents its data on `rx_data`. In format 01, bit 7 of `rx_data` is 0. A one-cycle `rx_rd` clears `rx_valid`.
- R8: When `par_chk`=1 and the format carries parity, a received parity bit that disagrees with R4 sets `pe_flag`. When `par_chk`=0, no parity error is recorded.
- R9: Any expected stop bit sampled low sets `fe_flag` if `fe_en`=1, and nothing is recorded if `fe_en`=0. The received data is still delivered. The receiver waits for the line to return high before looking for the next start bit.
- R10: A character that completes while `rx_valid`=1 and `rx_rd`=0 is dropped: `rx_data` keeps the unread byte, and `oe_flag` is set if `oe_en`=1.
- R11: When `cmd_we`=1, bits of `cmd` act as follows: [0] clears `fe_flag`, [1] clears `pe_flag`, [2] clears `oe_flag`, [3] clears `rx_en`, [4] sets `fe_flag`, [5] sets `pe_flag`, [6] sets `oe_flag`, [7] sets `rx_en`. A clear bit wins over the set bit for the same flag. Flags not addressed keep their value.
- R12: While `rx_en`=0 the receiver ignores the line, and no character or error is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| fmt | input | 2 | Format code: data width and parity presence |
| two_stop | input | 1 | 1 selects two stop bits |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| par_chk | input | 1 | Enables recording of parity errors |
| fe_en | input | 1 | Enables recording of framing errors |
| oe_en | input | 1 | Enables recording of overrun errors |
| cmd_we | input | 1 | Command word strobe |
| cmd | input | 8 | Set/clear command bits |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| tx_empty | output | 1 | Holding buffer is free |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_rd | input | 1 | Receive byte read strobe |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte not yet read |
| fe_flag | output | 1 | Sticky framing error |
| pe_flag | output | 1 | Sticky parity error |
| oe_flag | output | 1 | Sticky overrun error |
| rx_en | output | 1 | Receiver enable state |

## Verification
The bench sends back-to-back characters with two stop bits. A transmitter that sends only one stop bit starts the next character early, and the line monitor samples a low bit where it expects a stop. It writes into a full holding buffer, and a design that accepts this write sends the wrong byte. On the receive side it injects a short low glitch that a receiver skipping the mid-point check would turn into a character. It also drives a low stop bit and then a low second stop bit: a design that checks only the first stop misses the second fault, and a design that stores nothing in that case loses the data. Finally it lets two characters arrive unread. A design that overwrites the first byte, or that does not honour the recording enables and the clear-over-set rule, shows the wrong byte or the wrong flag.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;   // start + 8 data + parity + 2 stop
    localparam int NFLAG   = 4;    // fe, pe, oe, receiver enable

    typedef enum logic [1:0] {
        FMT_8N   = 2'b00,
        FMT_7P   = 2'b01,
        FMT_8P   = 2'b10,
        FMT_8N_X = 2'b11
    } fmt_e;

    function automatic logic [3:0] fmt_dbits(input logic [1:0] f);
        return (f == FMT_7P) ? 4'd7 : 4'd8;
    endfunction

    function automatic logic fmt_has_par(input logic [1:0] f);
        return (f == FMT_7P) || (f == FMT_8P);
    endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        fmt,
    input  logic              two_stop,
    input  logic              par_odd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              empty,
    output logic              txd,
    output logic              busy
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        logic [DATA_W-1:0]  hold;
        logic               full;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         left;
        logic [CW-1:0]      cnt;
        logic               busy;
    } tx_st_t;

    tx_st_t q, d;
    logic [FRAME_W-1:0] frm;
    logic [3:0]         db;
    logic               hp;
    logic               acc;

    always_comb begin
        d   = q;
        db  = fmt_dbits(fmt);
        hp  = fmt_has_par(fmt);
        frm = '1;
        frm[0] = 1'b0;
        acc = par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (4'(i) < db) begin
                frm[i+1] = q.hold[i];
                acc      = acc ^ q.hold[i];
            end
        end
        if (hp) frm[db + 4'd1] = acc;

        if (wr && !q.full) begin
            d.hold = wdata;
            d.full = 1'b1;
        end

        if (q.busy && tick) begin
            if (q.cnt == LAST) begin
                d.cnt  = '0;
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                d.left = q.left - 4'd1;
                if (q.left == 4'd1) d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (!q.busy && q.full) begin
            d.busy = 1'b1;
            d.full = 1'b0;
            d.cnt  = '0;
            d.sh   = frm;
            d.left = 4'd1 + db + 4'(hp) + (two_stop ? 4'd2 : 4'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{hold: '0, full: 1'b0, sh: '1, left: '0, cnt: '0, busy: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign empty = !q.full;
    assign txd   = q.busy ? q.sh[0] : 1'b1;
    assign busy  = q.busy;

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              ren,
    input  logic [1:0]        fmt,
    input  logic              two_stop,
    input  logic              par_odd,
    input  logic              par_chk,
    input  logic              fe_en,
    input  logic              oe_en,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              ev_fe,
    output logic              ev_pe,
    output logic              ev_oe
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [3:0]        idx;
        logic [DATA_W:0]   sh;
        logic              bad;
        logic [DATA_W-1:0] data;
        logic              valid;
    } rx_st_t;

    rx_st_t q, d;
    logic [3:0]        db, nb, ns;
    logic              hp, rxs, acc, pbit;
    logic [DATA_W-1:0] dat;

    always_comb begin
        d     = q;
        ev_fe = 1'b0;
        ev_pe = 1'b0;
        ev_oe = 1'b0;
        db    = fmt_dbits(fmt);
        hp    = fmt_has_par(fmt);
        nb    = db + 4'(hp);
        ns    = two_stop ? 4'd2 : 4'd1;
        rxs   = q.sync[1];
        d.sync = {q.sync[0], rxd};

        acc = par_odd;
        dat = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (4'(i) < db) begin
                dat[i] = q.sh[i];
                acc    = acc ^ q.sh[i];
            end
        end
        pbit = q.sh[db];

        if (rd) d.valid = 1'b0;

        case (q.st)
            RX_IDLE: begin
                if (tick && !rxs) begin
                    d.st  = RX_START;
                    d.cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rxs ? RX_IDLE : RX_BITS;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_BITS: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt        = '0;
                        d.sh[q.idx]  = rxs;
                        d.idx        = q.idx + 4'd1;
                        if (q.idx == nb - 4'd1) begin
                            d.st  = RX_STOP;
                            d.idx = '0;
                            d.bad = 1'b0;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.idx == ns - 4'd1) begin
                            d.st  = RX_WAITHI;
                            ev_fe = fe_en & (q.bad | !rxs);
                            ev_pe = hp & par_chk & (pbit != acc);
                            if (q.valid && !rd) begin
                                ev_oe = oe_en;
                            end else begin
                                d.data  = dat;
                                d.valid = 1'b1;
                            end
                        end else begin
                            d.idx = q.idx + 4'd1;
                            d.bad = q.bad | !rxs;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (rxs) d.st = RX_IDLE;
            end
        endcase

        if (!ren) d.st = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, st: RX_IDLE, cnt: '0, idx: '0, sh: '0,
                   bad: 1'b0, data: '0, valid: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.data;
    assign rvalid = q.valid;

endmodule

// File: rtl/uart_fe_flags.sv
module uart_fe_flags
    import uart_fe_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [2*NF-1:0] cmd,
    input  logic [NF-1:0]   ev,
    output logic [NF-1:0]   flags
);
    typedef struct packed {
        logic [NF-1:0] fl;
    } fl_st_t;

    fl_st_t q, d;
    logic [NF-1:0] clr, set;

    always_comb begin
        d   = q;
        clr = cmd_we ? cmd[NF-1:0]    : '0;
        set = cmd_we ? cmd[2*NF-1:NF] : '0;
        for (int i = 0; i < NF; i++) begin
            d.fl[i] = ev[i] | (!clr[i] & (q.fl[i] | set[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{fl: '0};
        end else begin
            q <= d;
        end
    end

    assign flags = q.fl;

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [1:0]        fmt,
    input  logic              two_stop,
    input  logic              par_odd,
    input  logic              par_chk,
    input  logic              fe_en,
    input  logic              oe_en,
    input  logic              cmd_we,
    input  logic [7:0]        cmd,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              fe_flag,
    output logic              pe_flag,
    output logic              oe_flag,
    output logic              rx_en
);
    logic             tx_busy;
    logic             ev_fe, ev_pe, ev_oe;
    logic [NFLAG-1:0] flg;

    uart_fe_tx #(.OSR(OSR)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .fmt(fmt),
        .two_stop(two_stop), .par_odd(par_odd), .wr(tx_we),
        .wdata(tx_data), .empty(tx_empty), .txd(txd), .busy(tx_busy)
    );

    uart_fe_rx #(.OSR(OSR)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd), .ren(rx_en),
        .fmt(fmt), .two_stop(two_stop), .par_odd(par_odd),
        .par_chk(par_chk), .fe_en(fe_en), .oe_en(oe_en), .rd(rx_rd),
        .rdata(rx_data), .rvalid(rx_valid),
        .ev_fe(ev_fe), .ev_pe(ev_pe), .ev_oe(ev_oe)
    );

    uart_fe_flags #(.NF(NFLAG)) flags_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
        .ev({1'b0, ev_oe, ev_pe, ev_fe}), .flags(flg)
    );

    assign fe_flag = flg[0];
    assign pe_flag = flg[1];
    assign oe_flag = flg[2];
    assign rx_en   = flg[3];

endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_empty,
    input logic       tx_we,
    input logic       tx_busy,
    input logic       cmd_we,
    input logic [7:0] cmd,
    input logic       ev_fe,
    input logic       fe_flag,
    input logic       oe_flag,
    input logic       rx_en,
    input logic       rx_valid,
    input logic       rx_rd,
    input logic [7:0] rx_data,
    input logic [1:0] fmt
);
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> !txd); // R2
    AST_BUF_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) tx_we && tx_empty |=> !tx_empty); // R5
    AST_BUF_FREED: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> tx_empty); // R5
    AST_MASK_SEVEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) && fmt == 2'b01 |-> !rx_data[7]); // R7
    AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid && !rx_rd |=> rx_valid && $stable(rx_data)); // R10
    AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) oe_flag && !(cmd_we && cmd[2]) |=> oe_flag); // R10
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) cmd_we && cmd[0] && !ev_fe |=> !fe_flag); // R11
    AST_REN_SET: assert property (@(posedge clk) disable iff (!rst_n) cmd_we && cmd[7] && !cmd[3] |=> rx_en); // R11
endmodule

bind uart_frame_engine uart_frame_engine_chk chk_i (.*);

// File: tb/uart_frame_engine_tb_top.sv
`timescale 1ns/1ps
module uart_frame_engine_tb_top;

    logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic       two_stop = 1'b0, par_odd = 1'b0, par_chk = 1'b1;
    logic       fe_en = 1'b1, oe_en = 1'b1;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic       tx_we = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_empty, txd;
    logic       rxd = 1'b1, rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, fe_flag, pe_flag, oe_flag, rx_en;

    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    typedef struct {
        logic [11:0] bits;
        int          len;
        string       tag;
    } frm_t;

    frm_t txq[$];

    always #2.5 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    uart_frame_engine dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic frm_t mk(input logic [7:0] d, input logic [1:0] f,
                                input bit two, input bit odd, input string tag);
        frm_t r;
        int   db;
        bit   hp, p;
        db = (f == 2'b01) ? 7 : 8;
        hp = (f == 2'b01) || (f == 2'b10);
        p  = odd;
        r.bits    = '1;
        r.bits[0] = 1'b0;
        for (int i = 0; i < db; i++) begin
            r.bits[1+i] = d[i];
            p = p ^ d[i];
        end
        if (hp) r.bits[1+db] = p;
        r.len = 1 + db + (hp ? 1 : 0) + (two ? 2 : 1);
        r.tag = tag;
        return r;
    endfunction

    task automatic tx_send(input logic [7:0] d, input string tag);
        while (!tx_empty) @(negedge clk);
        txq.push_back(mk(d, fmt, two_stop, par_odd, tag));
        tx_data = d;
        tx_we   = 1'b1;
        @(negedge clk);
        tx_we   = 1'b0;
    endtask

    task automatic wait_tx();
        while (txq.size() != 0) @(negedge clk);
        repeat (420) @(negedge clk);
    endtask

    task automatic rx_drive(input frm_t f);
        for (int k = 0; k < f.len; k++) begin
            rxd = f.bits[k];
            repeat (32) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd_write(input logic [7:0] v);
        cmd    = v;
        cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd    = 8'h00;
    endtask

    task automatic rx_read();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // Monitor: decodes the transmit line and compares against the queue
    initial begin : tx_monitor
        frm_t        e;
        logic [11:0] got;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                got = '1;
                repeat (15) @(negedge clk);
                got[0] = txd;
                if (txq.size() == 0) begin
                    chk("R5 unexpected tx frame", 32'd1, 32'd0);
                    repeat (400) @(negedge clk);
                end else begin
                    e = txq.pop_front();
                    for (int k = 1; k < e.len; k++) begin
                        repeat (32) @(negedge clk);
                        got[k] = txd;
                    end
                    chk(e.tag, {20'd0, got}, {20'd0, e.bits});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin : stim
        frm_t f;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", txd, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 flags", {rx_en, oe_flag, pe_flag, fe_flag}, 0);

        // R2 / R5 transmit, 8 data no parity
        tx_send(8'hA5, "R2 8N frame");
        chk("R5 empty low after write", tx_empty, 0);
        @(negedge clk);
        chk("R5 empty high after load", tx_empty, 1);
        wait_tx();

        fmt = 2'b01;
        tx_send(8'hD3, "R2 7P even frame");
        wait_tx();

        fmt = 2'b10; par_odd = 1'b1; two_stop = 1'b1;
        tx_send(8'h3C, "R4 8P odd frame");
        tx_send(8'h81, "R3 two stop back to back");
        tx_data = 8'hFF; tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
        chk("R5 write while full", tx_empty, 0);
        wait_tx();

        par_odd = 1'b0;
        tx_send(8'h07, "R4 8P even frame");
        wait_tx();

        fmt = 2'b11; two_stop = 1'b0;
        tx_send(8'h5A, "R2 code 11 as 8N");
        wait_tx();

        // R12 receiver disabled
        fmt = 2'b00;
        rx_drive(mk(8'h96, 2'b00, 0, 0, ""));
        chk("R12 disabled rx_valid", rx_valid, 0);

        cmd_write(8'h80);
        chk("R11 set rx_en", rx_en, 1);

        rx_drive(mk(8'h96, 2'b00, 0, 0, ""));
        chk("R7 valid 8N", rx_valid, 1);
        chk("R7 data 8N", rx_data, 8'h96);
        chk("R9 no flags clean frame", {oe_flag, pe_flag, fe_flag}, 0);
        rx_read();
        chk("R7 read clears valid", rx_valid, 0);

        // R7 seven-bit mask, R8 parity
        fmt = 2'b01;
        rx_drive(mk(8'hD5, 2'b01, 0, 0, ""));
        chk("R7 masked data", rx_data, 8'h55);
        chk("R8 good parity no pe", pe_flag, 0);
        rx_read();

        f = mk(8'h55, 2'b01, 0, 0, "");
        f.bits[8] = ~f.bits[8];
        rx_drive(f);
        chk("R8 bad parity sets pe", pe_flag, 1);
        chk("R8 data kept", rx_data, 8'h55);
        rx_read();
        cmd_write(8'h02);
        chk("R11 clear pe", pe_flag, 0);

        par_chk = 1'b0;
        rx_drive(f);
        chk("R8 check disabled", pe_flag, 0);
        rx_read();
        par_chk = 1'b1;

        // R6 glitch rejection
        fmt = 2'b00;
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (400) @(negedge clk);
        chk("R6 glitch ignored", rx_valid, 0);

        // R9 framing
        f = mk(8'h3A, 2'b00, 0, 0, "");
        f.bits[9] = 1'b0;
        rx_drive(f);
        chk("R9 low stop sets fe", fe_flag, 1);
        chk("R9 data delivered", {rx_valid, rx_data}, {1'b1, 8'h3A});
        rx_read();
        cmd_write(8'h01);
        chk("R11 clear fe", fe_flag, 0);

        fe_en = 1'b0;
        rx_drive(f);
        chk("R9 fe not recorded", fe_flag, 0);
        rx_read();
        fe_en = 1'b1;

        two_stop = 1'b1;
        f = mk(8'h11, 2'b00, 1, 0, "");
        f.bits[10] = 1'b0;
        rx_drive(f);
        chk("R3 second stop low sets fe", fe_flag, 1);
        rx_read();
        cmd_write(8'h01);
        two_stop = 1'b0;

        // R10 overrun
        rx_drive(mk(8'h21, 2'b00, 0, 0, ""));
        rx_drive(mk(8'h42, 2'b00, 0, 0, ""));
        chk("R10 overrun flagged", oe_flag, 1);
        chk("R10 unread byte kept", rx_data, 8'h21);
        cmd_write(8'h04);
        chk("R11 clear oe", oe_flag, 0);
        rx_read();

        oe_en = 1'b0;
        rx_drive(mk(8'h33, 2'b00, 0, 0, ""));
        rx_drive(mk(8'h44, 2'b00, 0, 0, ""));
        chk("R10 oe not recorded", oe_flag, 0);
        chk("R10 byte kept no record", rx_data, 8'h33);
        rx_read();
        oe_en = 1'b1;

        // R11 command word
        cmd_write(8'h20);
        chk("R11 set pe", pe_flag, 1);
        cmd_write(8'h22);
        chk("R11 clear wins over set", pe_flag, 0);
        cmd_write(8'h40);
        chk("R11 set oe only", {oe_flag, pe_flag, fe_flag}, 3'b100);
        cmd_write(8'h08);
        chk("R11 clear rx_en", rx_en, 0);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule